// File: doc/BRIEF.md
# Strided Shifted Load Address Unit

This unit carries out one vector-element load whose address is not a fixed base plus offset. The offset is the element step index times a sign-extended displacement, and that product is shifted left by an amount read from a register at run time. Stepping through elements with a shift chosen by software gives butterfly-style strides for FFT and DCT kernels.

An operation is presented with its access size, a zero-or-sign extension choice, an update choice, the displacement form, the base register value with a flag telling whether the base field names register zero, the shift-control register value, the step index and the immediate. The unit computes the address, issues a single read on a valid/ready request channel and waits for the response. It then pulses `done` with the formatted 64-bit result. For update forms it also returns the address to be written back to the base register. No status or condition flags are produced.

Top module: `strided_load_agu`

## Requirements
- R1: The shift amount n is `shift_reg[5:0]` (0 to 63). The address is base + ((step × sext(displacement)) << n) modulo 2^64. `step` is unsigned, the product is taken as a 64-bit two's-complement value, and bits shifted above bit 63 are lost.
- R2: For a non-update operation with `base_is_r0` high, the base is zero. With `base_is_r0` low, the base is `base_val`.
- R3: For an update operation the base is always `base_val`, and `base_is_r0` has no effect. `base_wb_en` is high with `done` only for update operations, and `base_wb_data` then equals the request address. A non-update operation leaves `base_wb_en` low.
- R4: With `op_ds_form` low, `disp_imm[15:0]` is sign-extended from bit 15. With `op_ds_form` high, `disp_imm[13:0]` gets two zero bits appended on the right and is sign-extended from bit 13. `disp_imm[15:14]` is ignored in that case.
- R5: The size code on `op_size` and `mem_req_size` is 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes and 3 = 8 bytes. With `op_signed` low, a 1-, 2- or 4-byte load places the right-justified response bytes in the low end of `result` and clears the rest.
- R6: With `op_signed` high, a 2- or 4-byte load sign-extends to 64 bits. An 8-byte load returns `mem_rsp_data` unchanged whatever `op_signed` is.
- R7: An accepted operation produces exactly one request, starting the cycle after acceptance. `mem_req_valid` holds with a stable address and size until `mem_req_ready`, and `mem_req_size` equals the accepted `op_size`.
- R8: `op_ready` is high only while idle. An `op_valid` seen while busy is ignored and does not change the request in flight.
- R9: `done` is a single-cycle pulse in the cycle after the response is taken. A `mem_rsp_valid` that arrives while no response is awaited is ignored.
- R10: After reset `op_ready` is high, and `mem_req_valid`, `done` and `base_wb_en` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | Operation offered |
| op_ready | output | 1 | Unit idle and accepting |
| op_size | input | 2 | Access size code |
| op_signed | input | 1 | Sign-extend the loaded value |
| op_update | input | 1 | Update form (base write-back) |
| op_ds_form | input | 1 | Displacement takes two low zero bits |
| base_val | input | 64 | Base register contents |
| base_is_r0 | input | 1 | Base field names register zero |
| shift_reg | input | 64 | Shift-control register contents |
| step | input | 7 | Element step index |
| disp_imm | input | 16 | Displacement immediate |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Read request accepted |
| mem_req_addr | output | 64 | Read address |
| mem_req_size | output | 2 | Read size code |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 64 | Read data, right-justified |
| done | output | 1 | Result valid pulse |
| result | output | 64 | Formatted load result |
| base_wb_en | output | 1 | Write address back to base register |
| base_wb_data | output | 64 | Value for base register |

## Verification
An operation accepted at clock edge k raises `mem_req_valid`, with its address and size, right after edge k. After the edge where `mem_req_ready` is sampled high, the unit waits for data. The result, `done` and write-back outputs appear right after the edge that samples `mem_rsp_valid`, and `done` drops again one edge later. The bench drives on falling edges and samples on the falling edge after each of these rising edges. It checks the address and size while the request is held, which includes stalls of several cycles. It checks result and write-back only in the `done` cycle, and checks that `done` is low on the following cycle.

// File: rtl/sll_pkg.sv
package sll_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_DBL  = 2'd3
    } sll_size_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_WAIT = 2'd2
    } sll_state_e;

endpackage

// File: rtl/sll_addr_gen.sv
module sll_addr_gen #(
    parameter int XLEN   = 64,
    parameter int STEP_W = 7,
    parameter int DISP_W = 16
) (
    input  logic [XLEN-1:0]   base_val,
    input  logic              base_is_r0,
    input  logic              update,
    input  logic              ds_form,
    input  logic [XLEN-1:0]   shift_reg,
    input  logic [STEP_W-1:0] step,
    input  logic [DISP_W-1:0] disp_imm,
    output logic [XLEN-1:0]   ea
);
    localparam int SHAMT_W = $clog2(XLEN);

    logic [DISP_W-1:0] disp_field;
    logic [XLEN-1:0]   disp_ext;
    logic [XLEN-1:0]   step_ext;
    logic [XLEN-1:0]   product;
    logic [XLEN-1:0]   offset;
    logic [XLEN-1:0]   base_eff;

    always_comb begin
        // word-granular form: low field bits gain two zero bits, sign at the new top
        disp_field = ds_form ? {disp_imm[DISP_W-3:0], 2'b00} : disp_imm;
        disp_ext   = {{(XLEN-DISP_W){disp_field[DISP_W-1]}}, disp_field};
        step_ext   = {{(XLEN-STEP_W){1'b0}}, step};
        // low XLEN bits of an unsigned product equal the two's-complement product
        product    = disp_ext * step_ext;
        offset     = product << shift_reg[SHAMT_W-1:0];
        base_eff   = (!update && base_is_r0) ? '0 : base_val;
        ea         = base_eff + offset;
    end

endmodule

// File: rtl/sll_fmt.sv
module sll_fmt
    import sll_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  sll_size_e         size,
    input  logic              sext,
    input  logic [XLEN-1:0]   raw,
    output logic [XLEN-1:0]   value
);
    always_comb begin
        unique case (size)
            SZ_BYTE: value = {{(XLEN-8){sext & raw[7]}},   raw[7:0]};
            SZ_HALF: value = {{(XLEN-16){sext & raw[15]}}, raw[15:0]};
            SZ_WORD: value = {{(XLEN-32){sext & raw[31]}}, raw[31:0]};
            default: value = raw;
        endcase
    end

endmodule

// File: rtl/strided_load_agu.sv
module strided_load_agu
    import sll_pkg::*;
#(
    parameter int XLEN   = 64,
    parameter int STEP_W = 7,
    parameter int DISP_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    output logic              op_ready,
    input  logic [1:0]        op_size,
    input  logic              op_signed,
    input  logic              op_update,
    input  logic              op_ds_form,
    input  logic [XLEN-1:0]   base_val,
    input  logic              base_is_r0,
    input  logic [XLEN-1:0]   shift_reg,
    input  logic [STEP_W-1:0] step,
    input  logic [DISP_W-1:0] disp_imm,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [XLEN-1:0]   mem_req_addr,
    output logic [1:0]        mem_req_size,
    input  logic              mem_rsp_valid,
    input  logic [XLEN-1:0]   mem_rsp_data,
    output logic              done,
    output logic [XLEN-1:0]   result,
    output logic              base_wb_en,
    output logic [XLEN-1:0]   base_wb_data
);

    typedef struct packed {
        sll_state_e        state;
        logic [XLEN-1:0]   ea;
        sll_size_e         size;
        logic              sext;
        logic              upd;
        logic              done;
        logic              wb_en;
        logic [XLEN-1:0]   res;
    } agu_reg_t;

    agu_reg_t r_d, r_q;

    logic [XLEN-1:0] ea_calc;
    logic [XLEN-1:0] fmt_val;

    sll_addr_gen #(
        .XLEN   (XLEN),
        .STEP_W (STEP_W),
        .DISP_W (DISP_W)
    ) u_addr (
        .base_val   (base_val),
        .base_is_r0 (base_is_r0),
        .update     (op_update),
        .ds_form    (op_ds_form),
        .shift_reg  (shift_reg),
        .step       (step),
        .disp_imm   (disp_imm),
        .ea         (ea_calc)
    );

    sll_fmt #(
        .XLEN (XLEN)
    ) u_fmt (
        .size  (r_q.size),
        .sext  (r_q.sext),
        .raw   (mem_rsp_data),
        .value (fmt_val)
    );

    always_comb begin
        r_d       = r_q;
        r_d.done  = 1'b0;
        r_d.wb_en = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (op_valid) begin
                    r_d.state = ST_REQ;
                    r_d.ea    = ea_calc;
                    r_d.size  = sll_size_e'(op_size);
                    r_d.sext  = op_signed;
                    r_d.upd   = op_update;
                end
            end
            ST_REQ: begin
                if (mem_req_ready) begin
                    r_d.state = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (mem_rsp_valid) begin
                    r_d.state = ST_IDLE;
                    r_d.res   = fmt_val;
                    r_d.done  = 1'b1;
                    r_d.wb_en = r_q.upd;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, size: SZ_BYTE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign op_ready      = (r_q.state == ST_IDLE);
    assign mem_req_valid = (r_q.state == ST_REQ);
    assign mem_req_addr  = r_q.ea;
    assign mem_req_size  = r_q.size;
    assign done          = r_q.done;
    assign result        = r_q.res;
    assign base_wb_en    = r_q.wb_en;
    assign base_wb_data  = r_q.ea;

endmodule

// File: rtl/sll_agu_chk.sv
module sll_agu_chk #(
    parameter int XLEN = 64
) (
    input logic            clk,
    input logic            rst_n,
    input logic            op_valid,
    input logic            op_ready,
    input logic [1:0]      op_size,
    input logic            op_signed,
    input logic            mem_req_valid,
    input logic            mem_req_ready,
    input logic [XLEN-1:0] mem_req_addr,
    input logic [1:0]      mem_req_size,
    input logic            done,
    input logic [XLEN-1:0] result,
    input logic            base_wb_en,
    input logic [XLEN-1:0] base_wb_data
);
    logic [XLEN-1:0] seen_addr_q;
    logic [1:0]      seen_size_q;
    logic            seen_sext_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_addr_q <= '0;
            seen_size_q <= '0;
            seen_sext_q <= 1'b0;
        end else begin
            if (op_valid && op_ready) begin
                seen_sext_q <= op_signed;
                seen_size_q <= op_size;
            end
            if (mem_req_valid && mem_req_ready) begin
                seen_addr_q <= mem_req_addr;
            end
        end
    end

    p_accept_issues_r7: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && op_ready |=> mem_req_valid);

    p_req_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=>
            mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_size));

    p_size_match_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> mem_req_size == seen_size_q);

    p_busy_not_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !op_ready);

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_wb_with_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
        base_wb_en |-> done);

    p_wb_is_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done && base_wb_en |-> base_wb_data == seen_addr_q);

    p_byte_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done && !seen_sext_q && seen_size_q == 2'd0 |-> result[XLEN-1:8] == '0);

endmodule

bind strided_load_agu sll_agu_chk #(.XLEN(XLEN)) u_chk (.*);

// File: tb/strided_load_agu_test.sv
`timescale 1ns/1ps
module strided_load_agu_test;

    typedef struct packed {
        logic [1:0]  size;
        logic        sgn;
        logic        upd;
        logic        ds;
        logic        r0;
        logic [63:0] base;
        logic [63:0] shreg;
        logic [6:0]  step;
        logic [15:0] disp;
        logic [63:0] mem;
        logic [63:0] exp_ea;
        logic [63:0] exp_res;
    } vec_t;

    localparam int NVEC = 9;
    localparam vec_t VECS [NVEC] = '{
        // R1 R5: byte zero, n=0
        '{2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 64'h1000, 64'h0, 7'd3, 16'h0010,
          64'hFFFF_FFFF_FFFF_FFA5, 64'h1030, 64'hA5},
        // R1 R4: halfword zero, negative displacement, n from low six bits
        '{2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 64'h2000, 64'hFFFF_FFFF_FFFF_FFC2, 7'd5, 16'hFFFE,
          64'h1234_5678_9ABC_8001, 64'h1FD8, 64'h8001},
        // R2 R6: halfword signed, base forced to zero
        '{2'd1, 1'b1, 1'b0, 1'b0, 1'b1, 64'h100, 64'h1, 7'd2, 16'h0004,
          64'h8001, 64'h10, 64'hFFFF_FFFF_FFFF_8001},
        // R3 R5: word zero update, zero flag ignored
        '{2'd2, 1'b0, 1'b1, 1'b0, 1'b1, 64'h4000, 64'h3, 7'd1, 16'h0008,
          64'hDEAD_BEEF_8765_4321, 64'h4040, 64'h8765_4321},
        // R4 R6: word signed, DS form negative
        '{2'd2, 1'b1, 1'b0, 1'b1, 1'b0, 64'h8000, 64'h0, 7'd4, 16'h3FFF,
          64'hF000_0001, 64'h7FF0, 64'hFFFF_FFFF_F000_0001},
        // R3 R4 R6: doubleword DS update, top immediate bits ignored, max step
        '{2'd3, 1'b1, 1'b1, 1'b1, 1'b0, 64'h10_0000, 64'h4, 7'd127, 16'hC001,
          64'h8123_4567_89AB_CDEF, 64'h10_1FC0, 64'h8123_4567_89AB_CDEF},
        // R1: shift by 63
        '{2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 64'h0, 64'h3F, 7'd1, 16'h0001,
          64'h7F, 64'h8000_0000_0000_0000, 64'h7F},
        // R1: address wraps modulo 2^64
        '{2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 64'hFFFF_FFFF_FFFF_FFF0, 64'h0, 7'd1, 16'h0020,
          64'h1, 64'h10, 64'h1},
        // R1 R3: step zero update gives base
        '{2'd2, 1'b1, 1'b1, 1'b0, 1'b0, 64'h5555_0000, 64'h9, 7'd0, 16'h7FFF,
          64'h7FFF_FFFF, 64'h5555_0000, 64'h7FFF_FFFF}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic        op_ready;
    logic [1:0]  op_size = '0;
    logic        op_signed = 1'b0;
    logic        op_update = 1'b0;
    logic        op_ds_form = 1'b0;
    logic [63:0] base_val = '0;
    logic        base_is_r0 = 1'b0;
    logic [63:0] shift_reg = '0;
    logic [6:0]  step = '0;
    logic [15:0] disp_imm = '0;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [63:0] mem_req_addr;
    logic [1:0]  mem_req_size;
    logic        mem_rsp_valid = 1'b0;
    logic [63:0] mem_rsp_data = '0;
    logic        done;
    logic [63:0] result;
    logic        base_wb_en;
    logic [63:0] base_wb_data;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    strided_load_agu uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .op_valid      (op_valid),
        .op_ready      (op_ready),
        .op_size       (op_size),
        .op_signed     (op_signed),
        .op_update     (op_update),
        .op_ds_form    (op_ds_form),
        .base_val      (base_val),
        .base_is_r0    (base_is_r0),
        .shift_reg     (shift_reg),
        .step          (step),
        .disp_imm      (disp_imm),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_req_addr  (mem_req_addr),
        .mem_req_size  (mem_req_size),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .done          (done),
        .result        (result),
        .base_wb_en    (base_wb_en),
        .base_wb_data  (base_wb_data)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic put_op(input vec_t v);
        op_size    = v.size;
        op_signed  = v.sgn;
        op_update  = v.upd;
        op_ds_form = v.ds;
        base_is_r0 = v.r0;
        base_val   = v.base;
        shift_reg  = v.shreg;
        step       = v.step;
        disp_imm   = v.disp;
    endtask

    task automatic run_vec(input vec_t v, input int stall);
        @(negedge clk);
        chk("R8 ready when idle", 64'(op_ready), 64'd1);
        put_op(v);
        op_valid = 1'b1;
        @(negedge clk);
        op_valid = 1'b0;
        chk("R7 request after accept", 64'(mem_req_valid), 64'd1);
        for (int k = 0; k < stall; k++) begin
            @(negedge clk);
            chk("R7 request held", 64'(mem_req_valid), 64'd1);
        end
        chk("R1 address", mem_req_addr, v.exp_ea);
        chk("R7 size", 64'(mem_req_size), 64'(v.size));
        mem_req_ready = 1'b1;
        @(negedge clk);
        mem_req_ready = 1'b0;
        chk("R7 single request", 64'(mem_req_valid), 64'd0);
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = v.mem;
        @(negedge clk);
        mem_rsp_valid = 1'b0;
        mem_rsp_data  = '0;
        chk("R9 done", 64'(done), 64'd1);
        chk("R5 R6 result", result, v.exp_res);
        chk("R3 wb enable", 64'(base_wb_en), 64'(v.upd));
        if (v.upd) chk("R3 wb data", base_wb_data, v.exp_ea);
        @(negedge clk);
        chk("R9 done pulse", 64'(done), 64'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        vec_t alt;
        repeat (3) @(negedge clk);
        // R10: reset state
        chk("R10 op_ready", 64'(op_ready), 64'd1);
        chk("R10 mem_req_valid", 64'(mem_req_valid), 64'd0);
        chk("R10 done", 64'(done), 64'd0);
        chk("R10 base_wb_en", 64'(base_wb_en), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NVEC; i++) begin
            run_vec(VECS[i], i % 3);
        end

        // R9: stray response while idle is ignored
        @(negedge clk);
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = 64'hFFFF;
        @(negedge clk);
        mem_rsp_valid = 1'b0;
        chk("R9 stray response no done", 64'(done), 64'd0);
        chk("R9 stray response idle", 64'(op_ready), 64'd1);

        // R8: new operation while busy is ignored
        put_op(VECS[0]);
        op_valid = 1'b1;
        @(negedge clk);
        chk("R8 busy not ready", 64'(op_ready), 64'd0);
        alt = VECS[3];
        put_op(alt);
        @(negedge clk);
        @(negedge clk);
        op_valid = 1'b0;
        chk("R8 address unchanged", mem_req_addr, VECS[0].exp_ea);
        chk("R8 size unchanged", 64'(mem_req_size), 64'(VECS[0].size));
        mem_req_ready = 1'b1;
        @(negedge clk);
        mem_req_ready = 1'b0;
        // R9: no done before the response arrives
        @(negedge clk);
        chk("R9 wait for response", 64'(done), 64'd0);
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = VECS[0].mem;
        @(negedge clk);
        mem_rsp_valid = 1'b0;
        chk("R8 result of first op", result, VECS[0].exp_res);
        chk("R3 non-update no wb", 64'(base_wb_en), 64'd0);
        @(negedge clk);
        chk("R8 idle after busy op", 64'(op_ready), 64'd1);
        chk("R8 no second request", 64'(mem_req_valid), 64'd0);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule